// File: doc/BRIEF.md
# Three-Wire Synthesizer Register Loader

This block is the master side of a three-wire configuration link to a frequency synthesizer. The three wires are a serial clock, serial data and a latch strobe. A host places a 24-bit configuration word on the `word` input and pulses `start`. The block then sends the word one bit at a time, most significant bit first. After the last bit it raises the latch strobe. The synthesizer then copies the shifted word into the register picked by the two lowest bits of that word. Those two bits are the last ones on the wire.

All serial timing comes from the system clock. The block takes a set of minimum times in picoseconds and the system clock period. For each phase of the link it rounds the cycle count up, so that every minimum is met at the configured clock. `busy` stays high for the whole transfer, including a recovery gap after the latch pulse. A one-cycle `done` pulse tells a host sequencer that it may start the next register write at once.

Top module: `syn3w_loader`

## Requirements
- R1: A start accepted while idle captures `word` on that edge. Exactly WORD_W (default 24) rising edges of `ser_clk` follow, carrying bit WORD_W-1 first and bit 0 last. Changes to `word` after the accepting edge have no effect.
- R2: The two control bits, bit 1 and then bit 0, are the last two bits clocked before the latch strobe.
- R3: `ser_data` changes only in two cases: on the edge where `ser_clk` falls, or on the edge that accepts a start while `ser_clk` is low. It never changes while `ser_clk` is high, and never on the edge where `ser_clk` rises.
- R4: Each phase count is the ceiling of its minimum time divided by the clock period, and at least 1. `ser_clk` stays high for HIGH_CYC cycles, the count for max(high time, hold time), which is 2 at defaults. It stays low for LOW_CYC cycles between bits, the count for max(low time, setup time), which is 2 at defaults. It is low whenever the block is idle.
- R5: `ser_latch` rises GAP_CYC cycles after the final fall of `ser_clk` (1 at defaults). It is never high while `ser_clk` is high.
- R6: `ser_latch` stays high for exactly LE_CYC cycles (1 at defaults).
- R7: `busy` rises on the cycle after the start is accepted. It falls REC_CYC cycles after `ser_latch` falls (1 at defaults), so it is high for WORD_W*(HIGH_CYC+LOW_CYC)+GAP_CYC+LE_CYC+REC_CYC cycles (99 at defaults). A start while `busy` is high is ignored: it causes no extra latch pulse and does not change the word being sent. The first rising `ser_clk` of the next word comes at least REC_CYC+LOW_CYC cycles after the previous latch falls.
- R8: `done` is high for exactly one cycle, the first cycle in which `busy` is low after a transfer, and at no other time.
- R9: While reset is held, `ser_clk`, `ser_data`, `ser_latch`, `busy` and `done` are all low, and the bit counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to send `word`; honoured only while idle |
| word | input | WORD_W | Configuration word, control bits in [1:0] |
| busy | output | 1 | Transfer in progress, including latch recovery |
| done | output | 1 | One-cycle pulse when a transfer completes |
| ser_clk | output | 1 | Serial clock to the synthesizer |
| ser_data | output | 1 | Serial data, changed on falling `ser_clk` |
| ser_latch | output | 1 | Latch strobe, high after the last bit |

## Verification
Every result is due at a fixed cycle after the stimulus that causes it:
- `busy` follows an accepted start by one cycle.
- The first `ser_clk` rise comes LOW_CYC cycles after that.
- The latch rises GAP_CYC cycles after the last clock fall.
- `busy` and `done` change REC_CYC cycles after the latch falls.

The monitor samples on every falling system-clock edge. It keeps run-length counters for each phase since its last observed transition and compares them with the exact counts. It pops the expected word from the scoreboard queue only at the latch rise. This way each timing check lands on the single sample where the result must first appear.

// File: rtl/syn3w_pkg.sv
package syn3w_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOW,
      ST_HIGH,
      ST_GAP,
      ST_LATCH,
      ST_REC
   } seq_state_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // Cycles needed to cover min_ps at period per_ps, rounded up, never below 1.
   function automatic int phase_cycles(input int min_ps, input int per_ps);
      int c;
      c = (min_ps + per_ps - 1) / per_ps;
      return (c < 1) ? 1 : c;
   endfunction

endpackage

// File: rtl/syn3w_phase_timer.sv
module syn3w_phase_timer #(
   parameter int MAX_CYC = 2,
   localparam int CW = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   if (MAX_CYC < 1) begin : g_bad_cyc
      $error("syn3w_phase_timer: MAX_CYC must be at least 1");
   end

   generate
      if (MAX_CYC > 1) begin : g_counter
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (load)
               cnt_q <= load_val;
            else if (cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end

         assign expired = (cnt_q == '0);
      end else begin : g_single
         // Every phase lasts one cycle: no counter is needed.
         logic unused_timer;
         assign unused_timer = ^{clk, rst_n, load, load_val};
         assign expired      = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/syn3w_shifter.sv
module syn3w_shifter #(
   parameter int WORD_W = 24,
   localparam int BW = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word,
   input  logic              advance,
   output logic              ser_bit,
   output logic              last_bit
);

   logic [WORD_W-1:0] sreg_q;
   logic [BW-1:0]     bitcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q   <= '0;
         bitcnt_q <= '0;
      end else if (load) begin
         sreg_q   <= word;
         bitcnt_q <= '0;
      end else if (advance) begin
         sreg_q   <= {sreg_q[WORD_W-2:0], 1'b0};
         bitcnt_q <= bitcnt_q + 1'b1;
      end
   end

   assign ser_bit  = sreg_q[WORD_W-1];
   assign last_bit = (bitcnt_q == BW'(WORD_W - 1));

   AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt_q < BW'(WORD_W)); // R1

   AST_NO_SHIFT_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load) |-> !last_bit); // R1

endmodule

// File: rtl/syn3w_seq.sv
module syn3w_seq
   import syn3w_pkg::*;
#(
   parameter int LOW_CYC  = 2,
   parameter int HIGH_CYC = 2,
   parameter int GAP_CYC  = 1,
   parameter int LE_CYC   = 1,
   parameter int REC_CYC  = 1,
   localparam int MAX_CYC = imax(imax(imax(LOW_CYC, HIGH_CYC), imax(GAP_CYC, LE_CYC)), REC_CYC),
   localparam int CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic last_bit,
   output logic load_word,
   output logic shift_bit,
   output logic ser_clk,
   output logic ser_latch,
   output logic busy,
   output logic done
);

   seq_state_t    state_q, state_d;
   logic          tmr_load;
   logic [CW-1:0] tmr_val;
   logic          tmr_exp;

   syn3w_phase_timer #(.MAX_CYC(MAX_CYC)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   always_comb begin
      state_d   = state_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      load_word = 1'b0;
      shift_bit = 1'b0;
      unique case (state_q)
         ST_IDLE: if (start) begin
            state_d   = ST_LOW;
            tmr_load  = 1'b1;
            tmr_val   = CW'(LOW_CYC - 1);
            load_word = 1'b1;
         end
         ST_LOW: if (tmr_exp) begin
            state_d  = ST_HIGH;
            tmr_load = 1'b1;
            tmr_val  = CW'(HIGH_CYC - 1);
         end
         ST_HIGH: if (tmr_exp) begin
            tmr_load = 1'b1;
            if (last_bit) begin
               state_d = ST_GAP;
               tmr_val = CW'(GAP_CYC - 1);
            end else begin
               state_d   = ST_LOW;
               tmr_val   = CW'(LOW_CYC - 1);
               shift_bit = 1'b1;
            end
         end
         ST_GAP: if (tmr_exp) begin
            state_d  = ST_LATCH;
            tmr_load = 1'b1;
            tmr_val  = CW'(LE_CYC - 1);
         end
         ST_LATCH: if (tmr_exp) begin
            state_d  = ST_REC;
            tmr_load = 1'b1;
            tmr_val  = CW'(REC_CYC - 1);
         end
         ST_REC: if (tmr_exp) begin
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         ser_clk   <= 1'b0;
         ser_latch <= 1'b0;
         busy      <= 1'b0;
         done      <= 1'b0;
      end else begin
         state_q   <= state_d;
         ser_clk   <= (state_d == ST_HIGH);
         ser_latch <= (state_d == ST_LATCH);
         busy      <= (state_d != ST_IDLE);
         done      <= (state_q == ST_REC) && (state_d == ST_IDLE);
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ser_clk && !ser_latch)); // R4

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy)); // R8

endmodule

// File: rtl/syn3w_loader.sv
module syn3w_loader
   import syn3w_pkg::*;
#(
   parameter int WORD_W        = 24,
   parameter int CLK_PERIOD_PS = 20000,
   parameter int T_SETUP_PS    = 10000,
   parameter int T_HOLD_PS     = 10000,
   parameter int T_HIGH_PS     = 25000,
   parameter int T_LOW_PS      = 25000,
   parameter int T_CLK2LE_PS   = 10000,
   parameter int T_LEPW_PS     = 20000,
   parameter int T_LESU_PS     = 20000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] word,
   output logic              busy,
   output logic              done,
   output logic              ser_clk,
   output logic              ser_data,
   output logic              ser_latch
);

   localparam int LOW_CYC  = phase_cycles(imax(T_LOW_PS, T_SETUP_PS), CLK_PERIOD_PS);
   localparam int HIGH_CYC = phase_cycles(imax(T_HIGH_PS, T_HOLD_PS), CLK_PERIOD_PS);
   localparam int GAP_CYC  = phase_cycles(T_CLK2LE_PS, CLK_PERIOD_PS);
   localparam int LE_CYC   = phase_cycles(T_LEPW_PS, CLK_PERIOD_PS);
   localparam int REC_CYC  = phase_cycles(T_LESU_PS, CLK_PERIOD_PS);

   if (WORD_W < 3) begin : g_bad_width
      $error("syn3w_loader: WORD_W must hold data plus two control bits");
   end
   if (CLK_PERIOD_PS <= 0) begin : g_bad_period
      $error("syn3w_loader: CLK_PERIOD_PS must be positive");
   end

   logic load_word;
   logic shift_bit;
   logic last_bit;

   syn3w_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_word),
      .word     (word),
      .advance  (shift_bit),
      .ser_bit  (ser_data),
      .last_bit (last_bit)
   );

   syn3w_seq #(
      .LOW_CYC  (LOW_CYC),
      .HIGH_CYC (HIGH_CYC),
      .GAP_CYC  (GAP_CYC),
      .LE_CYC   (LE_CYC),
      .REC_CYC  (REC_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .last_bit  (last_bit),
      .load_word (load_word),
      .shift_bit (shift_bit),
      .ser_clk   (ser_clk),
      .ser_latch (ser_latch),
      .busy      (busy),
      .done      (done)
   );

   AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_data)); // R3

   AST_DATA_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_clk) |-> $stable(ser_data)); // R3

   AST_LATCH_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ser_latch |-> !ser_clk); // R5

   AST_LATCH_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ser_latch |-> busy); // R7

endmodule

// File: tb/syn3w_loader_tb.sv
module syn3w_loader_tb;

   // Expected phase counts at a 20 ns clock (R4..R7), rounded up from the minimums.
   localparam int LOW_CYC  = 2;  // max(25,10) ns
   localparam int HIGH_CYC = 2;  // max(25,10) ns
   localparam int GAP_CYC  = 1;  // 10 ns
   localparam int LE_CYC   = 1;  // 20 ns
   localparam int REC_CYC  = 1;  // 20 ns
   localparam int TOTAL    = 24 * (LOW_CYC + HIGH_CYC) + GAP_CYC + LE_CYC + REC_CYC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] word = '0;
   logic        busy, done, ser_clk, ser_data, ser_latch;

   int n_checks = 0;
   int n_fail   = 0;
   int n_pushed = 0;
   int n_latch  = 0;
   logic [23:0] exp_q[$];

   always #10 clk = ~clk;

   syn3w_loader u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .word      (word),
      .busy      (busy),
      .done      (done),
      .ser_clk   (ser_clk),
      .ser_data  (ser_data),
      .ser_latch (ser_latch)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   // Driver: waits for idle, issues a start and pushes the expected word.
   task automatic send(input logic [23:0] w);
      @(negedge clk);
      while (busy) @(negedge clk);
      start = 1'b1;
      word  = w;
      exp_q.push_back(w);
      n_pushed++;
      @(negedge clk);
      chk(busy == 1'b1, "R7 busy one cycle after start", busy, 1);
      start = 1'b0;
      word  = ~w;  // later changes to word must not matter (R1)
   endtask

   // A start while busy must be ignored (R7).
   task automatic spurious(input logic [23:0] w);
      @(negedge clk);
      start = 1'b1;
      word  = w;
      @(negedge clk);
      start = 1'b0;
   endtask

   // Monitor / scoreboard
   logic        p_clk, p_data, p_le, p_busy, p_done;
   logic [23:0] cap;
   int bitcnt, hi_run, lo_run, le_run, busy_run, since_fall, since_lefall;
   bit le_seen;

   always @(negedge clk) begin
      if (!rst_n) begin
         p_clk = 0; p_data = 0; p_le = 0; p_busy = 0; p_done = 0;
         cap = '0; bitcnt = 0; hi_run = 0; lo_run = 0; le_run = 0;
         busy_run = 0; since_fall = 0; since_lefall = 0; le_seen = 0;
      end else begin
         since_fall++;
         since_lefall++;
         if (ser_data !== p_data)
            chk(!ser_clk && (p_clk || !p_busy), "R3 data change timing", ser_clk, 0);
         if (ser_clk && !p_clk) begin
            cap = {cap[22:0], ser_data};
            bitcnt++;
            if (bitcnt > 1)
               chk(lo_run == LOW_CYC, "R4 low time", lo_run, LOW_CYC);
            else if (le_seen)
               chk(since_lefall >= REC_CYC + LOW_CYC, "R7 latch to next clock",
                   since_lefall, REC_CYC + LOW_CYC);
            hi_run = 1;
         end else if (ser_clk) begin
            hi_run++;
         end
         if (!ser_clk && p_clk) begin
            chk(hi_run == HIGH_CYC, "R4 high time", hi_run, HIGH_CYC);
            lo_run = 1;
            since_fall = 0;
         end else if (!ser_clk) begin
            lo_run++;
         end
         if (!busy)
            chk(!ser_clk, "R4 idle clock low", ser_clk, 0);
         if (ser_latch && !p_le) begin
            logic [23:0] e;
            e = exp_q.size() > 0 ? exp_q.pop_front() : 24'hxxxxxx;
            n_latch++;
            chk(since_fall == GAP_CYC, "R5 clock to latch gap", since_fall, GAP_CYC);
            chk(bitcnt == 24, "R1 bit count", bitcnt, 24);
            chk(cap === e, "R1 word MSB first", cap, e);
            chk(cap[1:0] === e[1:0], "R2 control bits last", cap[1:0], e[1:0]);
            le_run = 1;
            bitcnt = 0;
         end else if (ser_latch) begin
            le_run++;
         end
         if (ser_latch)
            chk(!ser_clk, "R5 latch with clock low", ser_clk, 0);
         if (!ser_latch && p_le) begin
            chk(le_run == LE_CYC, "R6 latch width", le_run, LE_CYC);
            since_lefall = 0;
            le_seen = 1;
         end
         if (busy && !p_busy) busy_run = 1;
         else if (busy) busy_run++;
         if (!busy && p_busy) begin
            chk(busy_run == TOTAL, "R7 busy length", busy_run, TOTAL);
            chk(since_lefall == REC_CYC, "R7 recovery", since_lefall, REC_CYC);
            chk(done == 1'b1, "R8 done at busy fall", done, 1);
         end else if (done) begin
            chk(1'b0, "R8 spurious done", done, 0);
         end
         p_clk = ser_clk; p_data = ser_data; p_le = ser_latch;
         p_busy = busy; p_done = done;
      end
   end

   // Watchdog
   initial begin
      repeat (50000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk({ser_clk, ser_data, ser_latch, busy, done} == 5'b0, "R9 reset outputs",
          {ser_clk, ser_data, ser_latch, busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({ser_clk, ser_latch, busy, done} == 4'b0, "R9 idle after reset",
          {ser_clk, ser_latch, busy, done}, 0);

      send(24'hA5C396);
      send(24'h000000);
      send(24'hFFFFFF);
      send(24'h800001);
      send(24'h123456);
      // R7: start while busy ignored
      send(24'h3C0F02);
      repeat (20) @(negedge clk);
      spurious(24'hDEAD03);
      // back-to-back sequence
      for (int i = 0; i < 4; i++) send(24'h5A5A00 | 24'(i));
      send(24'h7FFFFE);

      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(n_latch == n_pushed, "R7 one latch per accepted start", n_latch, n_pushed);
      chk(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
      finish_run();
   end

endmodule